// File: doc/BRIEF.md
# Rotate-Zoom-Crop Source Address Generator

This block is the address front end of an image rotate, zoom and crop engine. It walks the output raster one pixel per clock and maps each destination pixel back to a fractional position in a cropped window of the source frame. Rotation is about the centre of the output image. The rotation angle arrives as precomputed signed cosine and sine values with eight fraction bits, so the block contains no trigonometric logic. The zoom arrives as a precomputed reciprocal, so the block contains no divider.

For every output pixel the block gives four things. The first is the linear frame-buffer addresses of the four source pixels that surround the mapped position: upper-left, upper-right, lower-left and lower-right. The second is the fractional row and column parts of the position, which a downstream bilinear interpolator uses as weights. The third is a flag that marks positions whose four neighbours do not all lie inside the crop window. The fourth is a strobe for the last pixel of the frame.

Five 16-bit parameter registers sit behind a small write port. A one-cycle start pulse launches a frame scan. The arithmetic runs through a four-stage pipeline that takes one coordinate per clock.

Top module: `rzc_addr_gen`

## Requirements
- R1: After reset, res_valid and res_last are low and the parameters hold the identity setting: cosine 0x0100, sine 0, inverse zoom 0x0100 and both crop origins 0.
- R2: A write with cfg_we high loads cfg_wdata into one of these registers: 0x0E for the crop column origin, 0x10 for the crop row origin, 0x12 for the inverse zoom (unsigned 8.8), 0x14 for the cosine and 0x16 for the sine (both signed 8.8). A write to any other address changes nothing.
- R3: A start pulse while idle scans the OUT_H by OUT_W output raster in row-major order from (0,0). It gives exactly OUT_H*OUT_W results, and res_last is high only with the final result.
- R4: The first result is valid after the fourth rising edge that follows the edge which samples scan_start. Later results follow on consecutive cycles.
- R5: With dr = row - OUT_H/2 and dc = col - OUT_W/2, the rotated offsets are rr = dr*cos + dc*sin and rc = dc*cos - dr*sin, with 8 fraction bits.
- R6: The source position inside the crop window is p = floor(r*izoom / 256) + (half crop dimension)*256 for each axis. The half dimension is CROP_H/2 for rows and CROP_W/2 for columns.
- R7: wt_row and wt_col are the low 8 bits of the row and column positions. The integer parts ri and ci select the upper-left neighbour.
- R8: For an in-range result, addr_tl = (y0+ri)*PITCH + x0+ci. The other neighbours are addr_tr = addr_tl+1, addr_bl = addr_tl+PITCH and addr_br = addr_bl+1.
- R9: res_oor is high when ri<0, ri>CROP_H-2, ci<0 or ci>CROP_W-2. With res_oor high, all four addresses and both weights are zero.
- R10: A start pulse during a scan is ignored and does not restart or lengthen the frame.
- R11: In the cycle after res_last, res_valid is low, and it stays low until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Parameter write enable |
| cfg_addr | input | 5 | Parameter register address |
| cfg_wdata | input | 16 | Parameter write data |
| scan_start | input | 1 | Starts a frame scan when idle |
| res_valid | output | 1 | Result strobe |
| res_last | output | 1 | Final pixel of the frame |
| res_oor | output | 1 | Neighbourhood outside the crop window |
| addr_tl | output | AW | Upper-left neighbour address |
| addr_tr | output | AW | Upper-right neighbour address |
| addr_bl | output | AW | Lower-left neighbour address |
| addr_br | output | AW | Lower-right neighbour address |
| wt_row | output | 8 | Fractional row weight |
| wt_col | output | 8 | Fractional column weight |

## Verification
The neighbour assertions assume that the crop origins and the mapped positions keep (y0+ri)*PITCH+x0+ci below 2^AW, because address wraparound would break the +1 and +PITCH relations. The stimulus therefore uses crop origins of a few pixels and angle and zoom settings whose in-range positions stay inside a 32 by 32 frame. The latency assertion assumes that parameters are stable while a frame is in flight, so the bench writes registers only between scans. The bench does send one stray start pulse in the middle of a scan.

// File: rtl/rzc_pkg.sv
package rzc_pkg;
   localparam int FRAC    = 8;
   localparam int CFG_AW  = 5;
   localparam int CFG_DW  = 16;

   localparam logic [CFG_AW-1:0] ADR_COL_ORG = 5'h0E;
   localparam logic [CFG_AW-1:0] ADR_ROW_ORG = 5'h10;
   localparam logic [CFG_AW-1:0] ADR_IZOOM   = 5'h12;
   localparam logic [CFG_AW-1:0] ADR_COS     = 5'h14;
   localparam logic [CFG_AW-1:0] ADR_SIN     = 5'h16;

   localparam logic [CFG_DW-1:0] UNITY = 16'h0100;

   typedef struct packed {
      logic [CFG_DW-1:0]        col_org;
      logic [CFG_DW-1:0]        row_org;
      logic [CFG_DW-1:0]        izoom;
      logic signed [CFG_DW-1:0] cosv;
      logic signed [CFG_DW-1:0] sinv;
   } rzc_cfg_t;
endpackage

// File: rtl/rzc_param_regs.sv
module rzc_param_regs
   import rzc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_AW-1:0] addr,
   input  logic [CFG_DW-1:0] wdata,
   output rzc_cfg_t          cfg
);
   // R2: only the five mapped addresses take writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.col_org <= '0;
         cfg.row_org <= '0;
         cfg.izoom   <= UNITY;
         cfg.cosv    <= UNITY;
         cfg.sinv    <= '0;
      end else if (we) begin
         case (addr)
            ADR_COL_ORG: cfg.col_org <= wdata;
            ADR_ROW_ORG: cfg.row_org <= wdata;
            ADR_IZOOM:   cfg.izoom   <= wdata;
            ADR_COS:     cfg.cosv    <= wdata;
            ADR_SIN:     cfg.sinv    <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rzc_raster.sv
module rzc_raster #(
   parameter int OUT_W = 8,
   parameter int OUT_H = 6,
   localparam int RCW  = $clog2((OUT_W > OUT_H) ? OUT_W : OUT_H) + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           iss_vld,
   output logic           iss_last,
   output logic [RCW-1:0] iss_row,
   output logic [RCW-1:0] iss_col
);
   localparam logic [RCW-1:0] ROW_MAX = RCW'(OUT_H - 1);
   localparam logic [RCW-1:0] COL_MAX = RCW'(OUT_W - 1);

   logic run;
   logic at_col_end, at_row_end;

   assign at_col_end = (iss_col == COL_MAX);
   assign at_row_end = (iss_row == ROW_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         iss_row <= '0;
         iss_col <= '0;
      end else if (!run) begin
         if (start) begin
            run     <= 1'b1;
            iss_row <= '0;
            iss_col <= '0;
         end
      end else if (at_col_end) begin
         iss_col <= '0;
         if (at_row_end) run <= 1'b0;
         else            iss_row <= iss_row + RCW'(1);
      end else begin
         iss_col <= iss_col + RCW'(1);
      end
   end

   assign iss_vld  = run;
   assign iss_last = run && at_col_end && at_row_end;
endmodule

// File: rtl/rzc_rotate.sv
module rzc_rotate
   import rzc_pkg::*;
#(
   parameter int CW      = 5,
   parameter int CROP_W  = 10,
   parameter int CROP_H  = 8,
   parameter bit CENTRE  = 1'b1,
   localparam int RW     = CW + CFG_DW + 1,
   localparam int PW     = RW + CFG_DW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic                 in_last,
   input  logic signed [CW-1:0] in_dr,
   input  logic signed [CW-1:0] in_dc,
   input  rzc_cfg_t             cfg,
   output logic                 out_vld,
   output logic                 out_last,
   output logic signed [PW-1:0] pos_r,
   output logic signed [PW-1:0] pos_c
);
   logic signed [RW-1:0] rot_r, rot_c;
   logic                 s2_vld, s2_last;
   logic signed [PW-1:0] ctr_r, ctr_c;
   logic signed [PW-1:0] iz;

   // variant: recentre into the crop window, or keep origin anchored
   generate
      if (CENTRE) begin : g_ctr
         assign ctr_r = PW'((CROP_H / 2) * (1 << FRAC));
         assign ctr_c = PW'((CROP_W / 2) * (1 << FRAC));
      end else begin : g_org
         assign ctr_r = '0;
         assign ctr_c = '0;
      end
   endgenerate

   assign iz = PW'($signed({1'b0, cfg.izoom}));

   // stage 2: rotation
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_last <= 1'b0;
         rot_r   <= '0;
         rot_c   <= '0;
      end else begin
         s2_vld  <= in_vld;
         s2_last <= in_last;
         rot_r   <= RW'(in_dr) * RW'(cfg.cosv) + RW'(in_dc) * RW'(cfg.sinv);
         rot_c   <= RW'(in_dc) * RW'(cfg.cosv) - RW'(in_dr) * RW'(cfg.sinv);
      end
   end

   // stage 3: zoom scaling and recentring
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_last <= 1'b0;
         pos_r    <= '0;
         pos_c    <= '0;
      end else begin
         out_vld  <= s2_vld;
         out_last <= s2_last;
         pos_r    <= ((PW'(rot_r) * iz) >>> FRAC) + ctr_r;
         pos_c    <= ((PW'(rot_c) * iz) >>> FRAC) + ctr_c;
      end
   end
endmodule

// File: rtl/rzc_neighbour.sv
module rzc_neighbour
   import rzc_pkg::*;
#(
   parameter int PW     = 39,
   parameter int AW     = 10,
   parameter int PITCH  = 32,
   parameter int CROP_W = 10,
   parameter int CROP_H = 8,
   localparam int IW    = PW - FRAC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic                 in_last,
   input  logic signed [PW-1:0] pos_r,
   input  logic signed [PW-1:0] pos_c,
   input  rzc_cfg_t             cfg,
   output logic                 out_vld,
   output logic                 out_last,
   output logic                 out_oor,
   output logic [3:0][AW-1:0]   out_addr,
   output logic [FRAC-1:0]      out_wr,
   output logic [FRAC-1:0]      out_wc
);
   localparam logic [AW-1:0]        PITCH_A = AW'(PITCH);
   localparam logic signed [IW-1:0] RI_MAX  = IW'(CROP_H - 2);
   localparam logic signed [IW-1:0] CI_MAX  = IW'(CROP_W - 2);

   logic signed [IW-1:0] ri, ci;
   logic                 oor;
   logic [AW-1:0]        row_a, base;
   logic [3:0][AW-1:0]   nb;

   assign ri = pos_r[PW-1:FRAC];
   assign ci = pos_c[PW-1:FRAC];

   assign oor = ri[IW-1] || ci[IW-1] || (ri > RI_MAX) || (ci > CI_MAX);

   assign row_a = AW'(cfg.row_org) + AW'(ri);
   assign base  = row_a * PITCH_A + AW'(cfg.col_org) + AW'(ci);

   // index bit 0 steps one column, bit 1 steps one line
   generate
      for (genvar k = 0; k < 4; k++) begin : g_nb
         localparam logic [AW-1:0] STEP =
            AW'(((k >> 1) & 1) * PITCH + (k & 1));
         assign nb[k] = base + STEP;
      end
   endgenerate

   // stage 4: split, range test, addresses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_last <= 1'b0;
         out_oor  <= 1'b0;
         out_addr <= '0;
         out_wr   <= '0;
         out_wc   <= '0;
      end else begin
         out_vld  <= in_vld;
         out_last <= in_last;
         out_oor  <= oor;
         out_addr <= oor ? '0 : nb;
         out_wr   <= oor ? '0 : pos_r[FRAC-1:0];
         out_wc   <= oor ? '0 : pos_c[FRAC-1:0];
      end
   end
endmodule

// File: rtl/rzc_addr_gen.sv
module rzc_addr_gen
   import rzc_pkg::*;
#(
   parameter int OUT_W      = 8,
   parameter int OUT_H      = 6,
   parameter int CROP_W     = 10,
   parameter int CROP_H     = 8,
   parameter int PITCH      = 32,
   parameter int FRAME_ROWS = 32,
   parameter bit CENTRE     = 1'b1,
   localparam int AW        = $clog2(PITCH * FRAME_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4:0]        cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic              scan_start,
   output logic              res_valid,
   output logic              res_last,
   output logic              res_oor,
   output logic [AW-1:0]     addr_tl,
   output logic [AW-1:0]     addr_tr,
   output logic [AW-1:0]     addr_bl,
   output logic [AW-1:0]     addr_br,
   output logic [7:0]        wt_row,
   output logic [7:0]        wt_col
);
   localparam int RCW = $clog2((OUT_W > OUT_H) ? OUT_W : OUT_H) + 1;
   localparam int CW  = RCW + 1;
   localparam int RW  = CW + CFG_DW + 1;
   localparam int PW  = RW + CFG_DW + 1;

   generate
      if (CROP_W < 2 || CROP_H < 2) begin : g_bad_crop
         $error("crop window needs at least two pixels per axis");
      end
      if (OUT_W < 1 || OUT_H < 1) begin : g_bad_out
         $error("output raster must not be empty");
      end
      if (PITCH < CROP_W) begin : g_bad_pitch
         $error("line pitch narrower than crop window");
      end
   endgenerate

   rzc_cfg_t cfg;
   logic           iss_vld, iss_last;
   logic [RCW-1:0] iss_row, iss_col;
   logic signed [CW-1:0] off_r, off_c;
   logic                 p1_vld, p1_last;
   logic signed [CW-1:0] p1_dr, p1_dc;
   logic                 p3_vld, p3_last;
   logic signed [PW-1:0] p3_pr, p3_pc;
   logic [3:0][AW-1:0]   nb_addr;

   rzc_param_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   rzc_raster #(.OUT_W(OUT_W), .OUT_H(OUT_H)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (scan_start),
      .iss_vld  (iss_vld),
      .iss_last (iss_last),
      .iss_row  (iss_row),
      .iss_col  (iss_col)
   );

   generate
      if (CENTRE) begin : g_half
         assign off_r = CW'(OUT_H / 2);
         assign off_c = CW'(OUT_W / 2);
      end else begin : g_zero
         assign off_r = '0;
         assign off_c = '0;
      end
   endgenerate

   // stage 1: destination offsets
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p1_vld  <= 1'b0;
         p1_last <= 1'b0;
         p1_dr   <= '0;
         p1_dc   <= '0;
      end else begin
         p1_vld  <= iss_vld;
         p1_last <= iss_last;
         p1_dr   <= $signed({1'b0, iss_row}) - off_r;
         p1_dc   <= $signed({1'b0, iss_col}) - off_c;
      end
   end

   rzc_rotate #(.CW(CW), .CROP_W(CROP_W), .CROP_H(CROP_H), .CENTRE(CENTRE)) u_rot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (p1_vld),
      .in_last  (p1_last),
      .in_dr    (p1_dr),
      .in_dc    (p1_dc),
      .cfg      (cfg),
      .out_vld  (p3_vld),
      .out_last (p3_last),
      .pos_r    (p3_pr),
      .pos_c    (p3_pc)
   );

   rzc_neighbour #(.PW(PW), .AW(AW), .PITCH(PITCH), .CROP_W(CROP_W), .CROP_H(CROP_H)) u_nb (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (p3_vld),
      .in_last  (p3_last),
      .pos_r    (p3_pr),
      .pos_c    (p3_pc),
      .cfg      (cfg),
      .out_vld  (res_valid),
      .out_last (res_last),
      .out_oor  (res_oor),
      .out_addr (nb_addr),
      .out_wr   (wt_row),
      .out_wc   (wt_col)
   );

   assign addr_tl = nb_addr[0];
   assign addr_tr = nb_addr[1];
   assign addr_bl = nb_addr[2];
   assign addr_br = nb_addr[3];
endmodule

// File: rtl/rzc_addr_gen_chk.sv
module rzc_addr_gen_chk #(
   parameter int AW    = 10,
   parameter int PITCH = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iss_vld,
   input logic          res_valid,
   input logic          res_last,
   input logic          res_oor,
   input logic [AW-1:0] addr_tl,
   input logic [AW-1:0] addr_tr,
   input logic [AW-1:0] addr_bl,
   input logic [AW-1:0] addr_br,
   input logic [7:0]    wt_row,
   input logic [7:0]    wt_col
);
   localparam logic [AW-1:0] PA  = AW'(PITCH);
   localparam logic [AW-1:0] ONE = AW'(1);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(iss_vld, 4));

   assert_last_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_last |-> res_valid);

   assert_quiet_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_last |=> !res_valid);

   assert_oor_zeroed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_oor) |->
         (addr_tl == '0 && addr_tr == '0 && addr_bl == '0 && addr_br == '0 &&
          wt_row == '0 && wt_col == '0));

   assert_neighbours_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_oor) |->
         (addr_tr == addr_tl + ONE && addr_bl == addr_tl + PA && addr_br == addr_bl + ONE));
endmodule

bind rzc_addr_gen rzc_addr_gen_chk #(.AW(AW), .PITCH(PITCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_vld   (iss_vld),
   .res_valid (res_valid),
   .res_last  (res_last),
   .res_oor   (res_oor),
   .addr_tl   (addr_tl),
   .addr_tr   (addr_tr),
   .addr_bl   (addr_bl),
   .addr_br   (addr_br),
   .wt_row    (wt_row),
   .wt_col    (wt_col)
);

// File: tb/tb_rzc_addr_gen.sv
module tb_rzc_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int OUT_W  = 8;
   localparam int OUT_H  = 6;
   localparam int CROP_W = 10;
   localparam int CROP_H = 8;
   localparam int PITCH  = 32;
   localparam int AW     = 10;
   localparam int NPIX   = OUT_W * OUT_H;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic scan_start = 1'b0;
   logic res_valid, res_last, res_oor;
   logic [AW-1:0] addr_tl, addr_tr, addr_bl, addr_br;
   logic [7:0] wt_row, wt_col;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   int cur_cos = 256, cur_sin = 0, cur_iz = 256, cur_x0 = 0, cur_y0 = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rzc_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .scan_start(scan_start), .res_valid(res_valid),
      .res_last(res_last), .res_oor(res_oor), .addr_tl(addr_tl), .addr_tr(addr_tr),
      .addr_bl(addr_bl), .addr_br(addr_br), .wt_row(wt_row), .wt_col(wt_col)
   );

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary();
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // expected result packed as tl,tr,bl,br,wr,wc,oor (R5 R6 R7 R8 R9)
   function automatic logic [63:0] model(input int r, input int c);
      int dr, dc, rr, rc, pr, pc, ri, ci, fr, fc, tl;
      logic [AW-1:0] a;
      dr = r - OUT_H / 2;
      dc = c - OUT_W / 2;
      rr = dr * cur_cos + dc * cur_sin;
      rc = dc * cur_cos - dr * cur_sin;
      pr = ((rr * cur_iz) >>> 8) + (CROP_H / 2) * 256;
      pc = ((rc * cur_iz) >>> 8) + (CROP_W / 2) * 256;
      ri = pr >>> 8;
      ci = pc >>> 8;
      fr = pr & 255;
      fc = pc & 255;
      if (ri < 0 || ci < 0 || ri > CROP_H - 2 || ci > CROP_W - 2)
         return 64'd1;
      tl = (cur_y0 + ri) * PITCH + cur_x0 + ci;
      a = AW'(tl);
      return {7'd0, a, AW'(tl + 1), AW'(tl + PITCH), AW'(tl + PITCH + 1),
              8'(fr), 8'(fc), 1'b0};
   endfunction

   task automatic run_frame(input string tag, input bit restart);
      int k, idx;
      logic [63:0] got, exp;
      @(negedge clk);
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      k = 0;
      idx = 0;
      check(!res_valid, "R4", {tag, " no result right after start"}, res_valid, 0);
      while (idx < NPIX && k < 200) begin
         @(negedge clk);
         k++;
         scan_start = (restart && k == 10);
         if (res_valid) begin
            // R4: result idx arrives after edge 4+idx
            check(k == 4 + idx, "R4", {tag, " result cycle"}, k, 4 + idx);
            got = {7'd0, addr_tl, addr_tr, addr_bl, addr_br, wt_row, wt_col, res_oor};
            exp = model(idx / OUT_W, idx % OUT_W);
            check(got == exp, "R8", {tag, " pixel data"}, got, exp);
            check(res_last == (idx == NPIX - 1), "R3", {tag, " last flag"},
                  res_last, idx == NPIX - 1);
            idx++;
         end
      end
      scan_start = 1'b0;
      check(idx == NPIX, "R3", {tag, " result count"}, idx, NPIX);
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         // R11 and R10: no extra results after the frame
         check(!res_valid, restart ? "R10" : "R11", {tag, " idle after last"}, res_valid, 0);
      end
   endtask

   task automatic setup(input int cs, input int sn, input int iz, input int x0, input int y0);
      wr(5'h14, cs);
      wr(5'h16, sn);
      wr(5'h12, iz);
      wr(5'h0E, x0);
      wr(5'h10, y0);
      cur_cos = cs; cur_sin = sn; cur_iz = iz; cur_x0 = x0; cur_y0 = y0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!res_valid && !res_last, "R1", "outputs during reset", {res_valid, res_last}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!res_valid && !res_last, "R1", "outputs after reset", {res_valid, res_last}, 0);
      // R1: defaults give the identity mapping
      run_frame("R1 defaults", 1'b0);
      // R2 R5: crop origin with identity
      setup(256, 0, 256, 3, 5);
      run_frame("R2 crop origin", 1'b0);
      // R5: quarter, half turn
      setup(0, 256, 256, 2, 4);
      run_frame("R5 90deg", 1'b0);
      setup(-256, 0, 256, 1, 1);
      run_frame("R5 180deg", 1'b0);
      // R6 R7: fractional angle with zoom 1.5
      setup(128, 222, 171, 4, 6);
      run_frame("R7 60deg zoom", 1'b0);
      // R6: zoom x2, 30 degrees
      setup(222, 128, 128, 6, 2);
      run_frame("R6 zoom2", 1'b0);
      // R9: zoom 0.5 pushes edges out of the window
      setup(256, 0, 512, 0, 0);
      run_frame("R9 shrink", 1'b0);
      // R5: negative sine
      setup(128, -222, 200, 5, 7);
      run_frame("R5 neg angle", 1'b0);
      // R2: writes to unmapped addresses are dropped
      wr(5'h1F, 16'hFFFF);
      wr(5'h15, 16'h1234);
      wr(5'h00, 16'h0BAD);
      run_frame("R2 unmapped writes", 1'b0);
      // R10: stray start mid-scan
      setup(222, -128, 256, 3, 3);
      run_frame("R10 restart", 1'b1);
      summary();
   end
endmodule